// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a multiple-register load or store. A requester gives it a word-aligned base address, a mask with one bit per register, one of four addressing modes and a writeback flag. The block then issues one word access per accepted memory handshake. Each access carries its byte address and the index of the register it serves. After the last access it pulses a completion strobe and presents the updated base address.

The four modes fix where the transfer sits relative to the base. Two modes step upward, either starting at the base or starting one word above it. Two modes cover the region below the base, either ending at the base or ending one word below it. In every mode the block walks the addresses from low to high, so the lowest-numbered selected register always uses the lowest address. A full-descending stack maps onto two of these modes: a pop uses increment-after and a push uses decrement-before.

Mode encoding on `mode_i`: 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before.

Top module: `xfer_seq`

## Requirements
- R1: Mode 0 (increment-after) with N selected registers accesses base, base+4, ... base+4N-4 and reports base+4N on `wb_base_o`.
- R2: Mode 1 (increment-before) accesses base+4 through base+4N and reports base+4N.
- R3: Mode 2 (decrement-after) accesses base-4N+4 through base and reports base-4N.
- R4: Mode 3 (decrement-before) accesses base-4N through base-4 and reports base-4N.
- R5: Accesses run in ascending address order, one word apart. The k-th access (counting from 0) carries the index of the k-th set bit of `reglist_i`, counting from bit 0 upward.
- R6: `mem_req_o` stays high, with `mem_addr_o` and `reg_idx_o` unchanged, until `mem_rdy_i` is sampled high. Each such cycle completes exactly one access. The first request appears in the cycle after `start_i` is taken.
- R7: An empty register mask makes no access. One cycle after start, `done_o` pulses and `wb_base_o` equals the base.
- R8: A base with nonzero bits [1:0] makes no access and no `done_o`. `align_err_o` pulses for one cycle, in the cycle after start.
- R9: `done_o` pulses for exactly one cycle, in the cycle after the last accepted access. `wb_we_o` equals `done_o` ANDed with the writeback flag captured at start. `wb_base_o` holds the updated base while `done_o` is high.
- R10: `start_i` is ignored while `busy_o` is high, and the running transfer is not disturbed.
- R11: After reset, `mem_req_o`, `busy_o`, `done_o`, `wb_we_o` and `align_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer; taken only when idle |
| base_i | input | AW | Base byte address |
| reglist_i | input | NREG | One bit per register to transfer |
| mode_i | input | 2 | Addressing mode (0 IA, 1 IB, 2 DA, 3 DB) |
| wb_en_i | input | 1 | Request writeback of the updated base |
| mem_req_o | output | 1 | Memory access request |
| mem_addr_o | output | AW | Word address of the current access |
| mem_rdy_i | input | 1 | Memory accepts the current access |
| reg_idx_o | output | IW | Register served by the current access |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_we_o | output | 1 | Write the updated base back |
| wb_base_o | output | AW | Updated base value |
| align_err_o | output | 1 | One-cycle pulse for a misaligned base |

## Verification
The bench uses the default build: a 32-bit address and a 16-entry register mask. These values make every mask size reachable, from empty to all sixteen registers, so it covers transfers of one word up to a full sweep of register indices. With a 32-bit address, decrementing modes on small bases wrap below zero, and the bench checks that wrapped arithmetic. Random ready stalls exercise holding an address across waits.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    XM_INC_AFTER  = 2'd0,
    XM_INC_BEFORE = 2'd1,
    XM_DEC_AFTER  = 2'd2,
    XM_DEC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xfer_state_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/xfer_popcnt.sv
module xfer_popcnt #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/xfer_lowbit.sv
module xfer_lowbit #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/xfer_span.sv
module xfer_span
  import xfer_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 5
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  xfer_mode_e    mode_i,
  output logic [AW-1:0] low_addr_o,
  output logic [AW-1:0] new_base_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] span;
  logic [AW-1:0] above;
  logic [AW-1:0] below;

  assign span  = AW'(cnt_i) << 2;
  assign above = base_i + span;
  assign below = base_i - span;

  always_comb begin
    unique case (mode_i)
      XM_INC_AFTER: begin
        low_addr_o = base_i;
        new_base_o = above;
      end
      XM_INC_BEFORE: begin
        low_addr_o = base_i + STEP;
        new_base_o = above;
      end
      XM_DEC_AFTER: begin
        low_addr_o = below + STEP;
        new_base_o = below;
      end
      default: begin
        low_addr_o = below;
        new_base_o = below;
      end
    endcase
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] reglist_i,
  input  logic [1:0]      mode_i,
  input  logic            wb_en_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rdy_i,
  output logic [IW-1:0]   reg_idx_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_base_o,
  output logic            align_err_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  xfer_state_e     state_q, state_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [NREG-1:0] pend_q, pend_d;
  logic [AW-1:0]   wbv_q, wbv_d;
  logic            wben_q, wben_d;
  logic            done_q, done_d;
  logic            err_q, err_d;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   low_addr;
  logic [AW-1:0]   new_base;
  logic [IW-1:0]   cur_idx;
  logic            pend_any;
  logic [NREG-1:0] pend_left;
  logic            accept;
  logic            misaligned;

  xfer_popcnt #(.W(NREG), .CW(CW)) u_cnt (
    .vec_i (reglist_i),
    .cnt_o (cnt)
  );

  xfer_span #(.AW(AW), .CW(CW)) u_span (
    .base_i     (base_i),
    .cnt_i      (cnt),
    .mode_i     (xfer_mode_e'(mode_i)),
    .low_addr_o (low_addr),
    .new_base_o (new_base)
  );

  xfer_lowbit #(.W(NREG), .IW(IW)) u_pick (
    .vec_i (pend_q),
    .idx_o (cur_idx),
    .any_o (pend_any)
  );

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign misaligned = |base_i[1:0];
  assign pend_left  = pend_q & ~(NREG'(1) << cur_idx);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    pend_d  = pend_q;
    wbv_d   = wbv_q;
    wben_d  = wben_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (misaligned) begin
            err_d = 1'b1;
          end else begin
            wbv_d  = new_base;
            wben_d = wb_en_i;
            if (cnt == '0) begin
              done_d = 1'b1;
            end else begin
              addr_d  = low_addr;
              pend_d  = reglist_i;
              state_d = ST_RUN;
            end
          end
        end
      end
      default: begin
        if (mem_rdy_i && pend_any) begin
          pend_d = pend_left;
          addr_d = addr_q + STEP;
          if (pend_left == '0) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pend_q  <= '0;
      wbv_q   <= '0;
      wben_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pend_q  <= pend_d;
      wbv_q   <= wbv_d;
      wben_q  <= wben_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign mem_req_o   = (state_q == ST_RUN);
  assign busy_o      = (state_q == ST_RUN);
  assign mem_addr_o  = addr_q;
  assign reg_idx_o   = cur_idx;
  assign done_o      = done_q;
  assign wb_we_o     = done_q & wben_q;
  assign wb_base_o   = wbv_q;
  assign align_err_o = err_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rdy_i,
  input logic [IW-1:0] reg_idx_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          wb_we_o,
  input logic          align_err_o
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(reg_idx_o)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(4))));

  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> (!mem_req_o || (reg_idx_o > $past(reg_idx_o))));

  p_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_req_o && !busy_o));

  p_wbwe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |-> done_o);

  p_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> (!mem_req_o && !done_o));
endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdy_i   (mem_rdy_i),
  .reg_idx_o   (reg_idx_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .wb_we_o     (wb_we_o),
  .align_err_o (align_err_o)
);

// File: tb/xfer_seq_tb.sv
module xfer_seq_tb;
  localparam int unsigned AW   = 32;
  localparam int unsigned NREG = 16;
  localparam int unsigned IW   = 4;
  localparam time CLK_PERIOD   = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [AW-1:0]   base_i = '0;
  logic [NREG-1:0] reglist_i = '0;
  logic [1:0]      mode_i = '0;
  logic            wb_en_i = 1'b0;
  logic            mem_req_o;
  logic [AW-1:0]   mem_addr_o;
  logic            mem_rdy_i = 1'b0;
  logic [IW-1:0]   reg_idx_o;
  logic            busy_o;
  logic            done_o;
  logic            wb_we_o;
  logic [AW-1:0]   wb_base_o;
  logic            align_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xfer_seq #(.AW(AW), .NREG(NREG)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .base_i (base_i),
    .reglist_i (reglist_i), .mode_i (mode_i), .wb_en_i (wb_en_i),
    .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o), .mem_rdy_i (mem_rdy_i),
    .reg_idx_o (reg_idx_o), .busy_o (busy_o), .done_o (done_o),
    .wb_we_o (wb_we_o), .wb_base_o (wb_base_o), .align_err_o (align_err_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [NREG-1:0] l);
    int n = 0;
    for (int i = 0; i < NREG; i++) n += int'(l[i]);
    return n;
  endfunction

  function automatic int nth_set(input logic [NREG-1:0] l, input int k);
    int seen = 0;
    for (int i = 0; i < NREG; i++) begin
      if (l[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  function automatic logic [AW-1:0] exp_low(input logic [AW-1:0] b, input int n, input logic [1:0] m);
    logic [AW-1:0] off = AW'(4 * n);
    case (m)
      2'd0: return b;
      2'd1: return b + 32'd4;
      2'd2: return b - off + 32'd4;
      default: return b - off;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_wb(input logic [AW-1:0] b, input int n, input logic [1:0] m);
    logic [AW-1:0] off = AW'(4 * n);
    return m[1] ? (b - off) : (b + off);
  endfunction

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // One full transfer, inputs driven and outputs sampled at falling edges.
  task automatic run_xfer(input logic [AW-1:0] b, input logic [NREG-1:0] l,
                          input logic [1:0] m, input bit wb, input bit poke);
    int n = popc(l);
    int k = 0;
    int guard = 0;
    bit poked = 0;
    logic [AW-1:0] low = exp_low(b, n, m);
    @(negedge clk);
    base_i = b; reglist_i = l; mode_i = m; wb_en_i = wb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (b[1:0] != 2'b00) begin
      chk(align_err_o == 1'b1, "R8 align_err", align_err_o, 1);
      chk(!mem_req_o && !done_o, "R8 no access", {mem_req_o, done_o}, 0);
      @(negedge clk);
      chk(align_err_o == 1'b0 && !mem_req_o, "R8 pulse end", {align_err_o, mem_req_o}, 0);
      return;
    end
    if (n == 0) begin
      chk(done_o && !mem_req_o, "R7 empty done", {done_o, mem_req_o}, 2);
      chk(wb_base_o == b, "R7 base kept", wb_base_o, b);
      chk(wb_we_o == wb, "R9 wb_we", wb_we_o, wb);
      @(negedge clk);
      chk(!done_o && !mem_req_o, "R7 pulse end", {done_o, mem_req_o}, 0);
      return;
    end
    while (!done_o) begin
      if (poke && k == 1 && !poked) begin
        start_i = 1'b1; base_i = b ^ 32'h0000_0F00; reglist_i = ~l; mode_i = ~m;
        poked = 1;
      end else begin
        start_i = 1'b0;
      end
      chk(mem_req_o && busy_o, "R6 request up", mem_req_o, 1);
      mem_rdy_i = ($urandom % 3) != 0;
      if (mem_req_o && mem_rdy_i) begin
        chk(mem_addr_o == low + AW'(4 * k), {mtag(m), " address"}, mem_addr_o, low + AW'(4 * k));
        chk(int'(reg_idx_o) == nth_set(l, k), "R5 register order", reg_idx_o, nth_set(l, k));
        k++;
      end
      @(negedge clk);
      guard++;
      if (guard > 200) begin
        chk(0, "R9 done missing", k, n);
        break;
      end
    end
    start_i = 1'b0;
    mem_rdy_i = 1'b0;
    chk(k == n, "R6 access count", k, n);
    chk(wb_base_o == exp_wb(b, n, m), {mtag(m), " writeback"}, wb_base_o, exp_wb(b, n, m));
    chk(wb_we_o == wb, "R9 wb_we", wb_we_o, wb);
    chk(!mem_req_o && !busy_o, "R9 idle at done", {mem_req_o, busy_o}, 0);
    @(negedge clk);
    chk(!done_o && !wb_we_o && !mem_req_o, "R10 pulse end, no stray start",
        {done_o, wb_we_o, mem_req_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!mem_req_o && !busy_o && !done_o && !wb_we_o && !align_err_o, "R11 reset",
        {mem_req_o, busy_o, done_o, wb_we_o, align_err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_o && !busy_o && !done_o, "R11 after release", {mem_req_o, busy_o, done_o}, 0);

    // Directed cases around base 0x100 with registers 1..3.
    for (int m = 0; m < 4; m++) run_xfer(32'h100, 16'h000E, 2'(m), 1'b1, 1'b0);
    run_xfer(32'h0000_2000, 16'hFFFF, 2'd3, 1'b1, 1'b0);  // push all
    run_xfer(32'h0000_1FC0, 16'hFFFF, 2'd0, 1'b0, 1'b0);  // pop all
    run_xfer(32'h0, 16'h8000, 2'd3, 1'b1, 1'b0);          // wraps below zero
    run_xfer(32'h40, 16'h0001, 2'd1, 1'b1, 1'b0);
    run_xfer(32'h80, 16'h0000, 2'd2, 1'b1, 1'b0);         // empty list R7
    run_xfer(32'h81, 16'h00F0, 2'd0, 1'b1, 1'b0);         // misaligned R8
    run_xfer(32'h300, 16'h0A51, 2'd2, 1'b1, 1'b1);        // start while busy R10

    for (int t = 0; t < 60; t++) begin
      logic [AW-1:0] b = $urandom;
      logic [NREG-1:0] l = NREG'($urandom);
      if (($urandom % 8) != 0) b[1:0] = 2'b00;
      if (($urandom % 10) == 0) l = '0;
      run_xfer(b, l, 2'($urandom), 1'($urandom), 1'(($urandom % 4) == 0));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule